// File: doc/BRIEF.md
# Host Bus Transaction Sequencer

This block decides when an outside host processor may take over the shared address, data, direction and byte-enable lines of the chip, and it walks each host transaction through a fixed series of states. A transaction is one of four kinds: a register transfer, a video-memory access, an external-device access, or a reserved kind. The kind is decoded from two select lines. Every hand-over of the shared lines is padded by one dead-band cycle, in which neither side drives. This applies when the host takes the lines and again when the chip takes them back.

All host-side pins are modelled active-high. The request and the address-latch strobe pass through a synchronizer whose depth is one or two flops, picked by a control input. The two select lines, the write enable and byte-enable bit 0 always pass through one flop. The block carries no data stream, so it has no valid/ready interface. Every pin is plain control or status, sampled on the rising clock edge. There is no back-pressure beyond the host holding its request and the memory side withholding its ready.

Top module: `host_xact_seq`

## Requirements
- R1: While reset is applied and just after it, `drv_en_o`=1 and `bus_en_o`, `rdy_o`, `mem_req_o`, `xfer_o` and `halt_req_o` are all 0.
- R2: `bus_en_o` rises 3 rising edges after `req_i` rises when `sync2_i`=0, and 4 edges after when `sync2_i`=1. The cycle just before the grant has `drv_en_o`=0 and `bus_en_o`=0. `drv_en_o` and `bus_en_o` are never 1 together.
- R3: For register, memory and reserved kinds, the sequencer holds in the grant state while the synchronized `ale_i` is 0. In that time `rdy_o`, `xfer_o` and `mem_req_o` stay 0.
- R4: The kind is decoded from {`reg_sel_i`,`mem_sel_i`}: 00 external, 10 register, 01 memory, 11 reserved. `rdy_o` is raised only for register and memory kinds.
- R5: A memory access gives exactly one `mem_req_o` pulse and then waits for `mem_rdy_i`. `rdy_o` is 1 in the cycle after `mem_rdy_i` is sampled in the wait state, and never before.
- R6: Once raised, `rdy_o` stays 1 for as long as the host keeps `req_i` high.
- R7: After `req_i` falls, `bus_en_o` falls 2 edges later with `sync2_i`=0, or 3 edges later with `sync2_i`=1. `rdy_o` falls with it. One cycle with `drv_en_o`=0 follows, and then `drv_en_o` returns to 1.
- R8: A register access gives exactly one one-cycle `xfer_o` strobe after the latch strobe is seen. `halt_req_o` pulses in that same cycle only when `cpu_halted_i`=0.
- R9: An external access is granted and then never raises `rdy_o`, `xfer_o`, `halt_req_o` or `mem_req_o` before release.
- R10: A reserved access waits for the latch strobe and then releases through the same dead-band sequence, with no `rdy_o`, `xfer_o`, `halt_req_o` or `mem_req_o`.
- R11: While `xfer_o` or `mem_req_o` is 1, `xfer_we_o` and `xfer_be0_o` equal the `we_i` and `be0_i` values the host held when the latch strobe was seen.
- R12: If `req_i` falls in the same cycle that `mem_rdy_i` arrives, the ready phase still runs. `rdy_o` is 1 for exactly 2 cycles before `bus_en_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync2_i | input | 1 | 1 selects two synchronizer stages on request and latch strobe |
| cpu_halted_i | input | 1 | Internal processor is already halted |
| req_i | input | 1 | Host request, asynchronous |
| reg_sel_i | input | 1 | Register-select |
| mem_sel_i | input | 1 | Memory-select |
| ale_i | input | 1 | Host address-latch strobe, asynchronous |
| we_i | input | 1 | Host write direction |
| be0_i | input | 1 | Host byte-enable bit 0 |
| mem_rdy_i | input | 1 | Memory controller done |
| bus_en_o | output | 1 | Grant of the shared lines to the host |
| drv_en_o | output | 1 | Chip may drive its own bus drivers |
| rdy_o | output | 1 | Data valid to host |
| mem_req_o | output | 1 | One-cycle memory request |
| xfer_o | output | 1 | One-cycle register transfer strobe |
| halt_req_o | output | 1 | Halt the internal processor for the transfer |
| xfer_we_o | output | 1 | Captured direction for the transfer |
| xfer_be0_o | output | 1 | Captured byte-enable bit 0 for the transfer |

## Verification
The case that matters most is the host dropping its request in the same cycle that memory-ready arrives. If the release were acted on early, the ready phase would be skipped. The bench provokes this with a directed memory access that drives both edges at one falling clock edge. It then judges the result by counting `rdy_o` cycles: there must be exactly two, and the grant must fall only after them. Random accesses that change kind, synchronizer depth, halt state and latch delay also stress the dead-band ordering at both ends.

// File: rtl/hxs_pkg.sv
package hxs_pkg;
  // cycle kind, bits are {register-select, memory-select}
  typedef enum logic [1:0] {
    CY_EXT = 2'b00,
    CY_MEM = 2'b01,
    CY_REG = 2'b10,
    CY_RSV = 2'b11
  } cyc_kind_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEAD_IN,
    ST_GRANT,
    ST_MREQ,
    ST_MWAIT,
    ST_DATA1,
    ST_DATAN,
    ST_PASS,
    ST_DEAD_OUT
  } seq_state_t;
endpackage

// File: rtl/hxs_sync.sv
module hxs_sync #(
  parameter int W          = 1,
  parameter int MAX_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         deep_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int LAST = MAX_STAGES - 1;

  logic [MAX_STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < MAX_STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  generate
    if (MAX_STAGES > 1) begin : g_sel
      assign q_o = deep_i ? stg[LAST] : stg[0];
    end else begin : g_fixed
      logic unused_deep;
      assign unused_deep = deep_i;
      assign q_o = stg[0];
    end
  endgenerate
endmodule

// File: rtl/hxs_fsm.sv
module hxs_fsm
  import hxs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  input  logic ale_s,
  input  logic reg_s,
  input  logic mem_s,
  input  logic we_s,
  input  logic be0_s,
  input  logic mem_rdy_i,
  input  logic cpu_halted_i,
  output logic bus_en_o,
  output logic drv_en_o,
  output logic rdy_o,
  output logic mem_req_o,
  output logic xfer_o,
  output logic halt_req_o,
  output logic xfer_we_o,
  output logic xfer_be0_o
);
  seq_state_t st, st_nx;
  cyc_kind_t  kind;
  logic       we_q, be0_q;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:     if (req_s) st_nx = ST_DEAD_IN;
      ST_DEAD_IN:  st_nx = ST_GRANT;
      ST_GRANT: begin
        if (kind == CY_EXT)      st_nx = ST_PASS;
        else if (ale_s) begin
          unique case (kind)
            CY_REG:  st_nx = ST_DATA1;
            CY_MEM:  st_nx = ST_MREQ;
            default: st_nx = ST_PASS;
          endcase
        end
      end
      ST_MREQ:     st_nx = ST_MWAIT;
      ST_MWAIT:    if (mem_rdy_i) st_nx = ST_DATA1;
      ST_DATA1:    st_nx = ST_DATAN;
      ST_DATAN:    if (!req_s) st_nx = ST_DEAD_OUT;
      ST_PASS:     if (!req_s) st_nx = ST_DEAD_OUT;
      ST_DEAD_OUT: st_nx = ST_IDLE;
      default:     st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      kind  <= CY_EXT;
      we_q  <= 1'b0;
      be0_q <= 1'b0;
    end else begin
      st <= st_nx;
      if (st == ST_IDLE && req_s) kind <= cyc_kind_t'({reg_s, mem_s});
      if (st == ST_GRANT && ale_s) begin
        we_q  <= we_s;
        be0_q <= be0_s;
      end
    end
  end

  assign drv_en_o   = (st == ST_IDLE);
  assign bus_en_o   = (st == ST_GRANT) || (st == ST_MREQ) || (st == ST_MWAIT) ||
                      (st == ST_DATA1) || (st == ST_DATAN) || (st == ST_PASS);
  assign rdy_o      = (st == ST_DATA1) || (st == ST_DATAN);
  assign mem_req_o  = (st == ST_MREQ);
  assign xfer_o     = (st == ST_DATA1) && (kind == CY_REG);
  assign halt_req_o = xfer_o && !cpu_halted_i;
  assign xfer_we_o  = we_q;
  assign xfer_be0_o = be0_q;
endmodule

// File: rtl/host_xact_seq.sv
module host_xact_seq #(
  parameter int REQ_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync2_i,
  input  logic cpu_halted_i,
  input  logic req_i,
  input  logic reg_sel_i,
  input  logic mem_sel_i,
  input  logic ale_i,
  input  logic we_i,
  input  logic be0_i,
  input  logic mem_rdy_i,
  output logic bus_en_o,
  output logic drv_en_o,
  output logic rdy_o,
  output logic mem_req_o,
  output logic xfer_o,
  output logic halt_req_o,
  output logic xfer_we_o,
  output logic xfer_be0_o
);
  logic [1:0] hs_s;
  logic [3:0] ctl_s;

  hxs_sync #(.W(2), .MAX_STAGES(REQ_STAGES)) i_sync_hs (
    .clk(clk), .rst_n(rst_n), .deep_i(sync2_i),
    .d_i({req_i, ale_i}), .q_o(hs_s)
  );

  hxs_sync #(.W(4), .MAX_STAGES(1)) i_sync_ctl (
    .clk(clk), .rst_n(rst_n), .deep_i(1'b0),
    .d_i({reg_sel_i, mem_sel_i, we_i, be0_i}), .q_o(ctl_s)
  );

  hxs_fsm i_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_s(hs_s[1]), .ale_s(hs_s[0]),
    .reg_s(ctl_s[3]), .mem_s(ctl_s[2]), .we_s(ctl_s[1]), .be0_s(ctl_s[0]),
    .mem_rdy_i(mem_rdy_i), .cpu_halted_i(cpu_halted_i),
    .bus_en_o(bus_en_o), .drv_en_o(drv_en_o), .rdy_o(rdy_o),
    .mem_req_o(mem_req_o), .xfer_o(xfer_o), .halt_req_o(halt_req_o),
    .xfer_we_o(xfer_we_o), .xfer_be0_o(xfer_be0_o)
  );
endmodule

// File: rtl/hxs_checker.sv
module hxs_checker (
  input logic clk,
  input logic rst_n,
  input logic cpu_halted_i,
  input logic bus_en_o,
  input logic drv_en_o,
  input logic rdy_o,
  input logic mem_req_o,
  input logic xfer_o,
  input logic halt_req_o
);
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en_o && drv_en_o));

  a_r2_deadband_in: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_en_o) |-> $past(!drv_en_o));

  a_r7_deadband_out: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_en_o) |-> !drv_en_o);

  a_r5_mem_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o && !rdy_o);

  a_r8_xfer_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_o |=> !xfer_o);

  a_r8_halt_gated: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req_o |-> xfer_o && !cpu_halted_i);

  a_r6_rdy_granted: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |-> bus_en_o);
endmodule

bind host_xact_seq hxs_checker i_chk (
  .clk(clk), .rst_n(rst_n), .cpu_halted_i(cpu_halted_i),
  .bus_en_o(bus_en_o), .drv_en_o(drv_en_o), .rdy_o(rdy_o),
  .mem_req_o(mem_req_o), .xfer_o(xfer_o), .halt_req_o(halt_req_o)
);

// File: tb/test_host_xact_seq.sv
module test_host_xact_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync2_i = 0, cpu_halted_i = 0, req_i = 0, reg_sel_i = 0, mem_sel_i = 0;
  logic ale_i = 0, we_i = 0, be0_i = 0, mem_rdy_i = 0;
  logic bus_en_o, drv_en_o, rdy_o, mem_req_o, xfer_o, halt_req_o, xfer_we_o, xfer_be0_o;

  int total = 0, bad = 0;
  int n_xfer, n_halt, n_mreq, n_rdy, n_capbad;
  bit exp_we, exp_be0;

  always #10ns clk = ~clk;  // 50 MHz

  host_xact_seq i_host_xact_seq (.*);

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: counts pulses each falling edge
  always @(negedge clk) begin
    if (xfer_o) n_xfer++;
    if (halt_req_o) n_halt++;
    if (mem_req_o) n_mreq++;
    if (rdy_o) n_rdy++;
    if ((xfer_o || mem_req_o) && (xfer_we_o != exp_we || xfer_be0_o != exp_be0)) n_capbad++;
  end

  function automatic int grant_lat(bit deep);   return deep ? 4 : 3; endfunction
  function automatic int release_lat(bit deep); return deep ? 3 : 2; endfunction
  function automatic bit has_rdy(int kind);     return kind == 1 || kind == 2; endfunction

  // kind: 0 external, 1 register, 2 memory, 3 reserved
  task automatic run_txn(int kind, bit deep, bit halted, int ale_dly, int hold, bit early);
    int n;
    bit prev_drv;
    @(negedge clk); #1;
    reg_sel_i = (kind == 1 || kind == 3);
    mem_sel_i = (kind == 2 || kind == 3);
    we_i = 1'($urandom); be0_i = 1'($urandom);
    exp_we = we_i; exp_be0 = be0_i;
    sync2_i = deep; cpu_halted_i = halted;
    repeat (3) @(negedge clk);
    #1;
    n_xfer = 0; n_halt = 0; n_mreq = 0; n_rdy = 0; n_capbad = 0;
    req_i = 1'b1;
    n = 0; prev_drv = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); n++;
      if (bus_en_o) break;
      prev_drv = drv_en_o;
    end
    chk(n == grant_lat(deep), "R2 grant latency", n, grant_lat(deep));
    chk(prev_drv == 1'b0, "R2 dead-band before grant", prev_drv, 0);
    if (kind != 0) begin
      repeat (ale_dly) @(negedge clk);
      chk(!rdy_o && bus_en_o && n_xfer == 0 && n_mreq == 0, "R3 wait for latch", rdy_o, 0);
    end
    #1; ale_i = 1'b1;
    if (kind == 2) begin
      repeat (5) @(negedge clk);
      chk(n_mreq == 1 && !rdy_o, "R5 request then wait", n_mreq, 1);
      #1; mem_rdy_i = 1'b1;
      if (early) req_i = 1'b0;
      @(negedge clk);
      #1; mem_rdy_i = 1'b0;
      chk(rdy_o == 1'b1, "R5 ready after memory done", rdy_o, 1);
      if (!early) begin
        repeat (hold) @(negedge clk);
        chk(rdy_o == 1'b1, "R6 ready held", rdy_o, 1);
      end
    end else begin
      repeat (hold) @(negedge clk);
      if (kind == 1) chk(rdy_o == 1'b1, "R6 ready held", rdy_o, 1);
      else chk(!rdy_o && bus_en_o, kind == 0 ? "R9 external passive" : "R10 reserved passive", rdy_o, 0);
    end
    #1;
    if (req_i) begin
      req_i = 1'b0;
      n = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk); n++;
        if (!bus_en_o) break;
      end
      chk(n == release_lat(deep), "R7 release latency", n, release_lat(deep));
    end else begin
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!bus_en_o) break;
      end
      chk(n_rdy == 2, "R12 ready phase survives early release", n_rdy, 2);
    end
    chk(!drv_en_o && !rdy_o, "R7 dead-band after release", drv_en_o, 0);
    #1; ale_i = 1'b0;
    @(negedge clk);
    chk(drv_en_o == 1'b1, "R7 drivers back", drv_en_o, 1);
    chk(n_xfer == (kind == 1 ? 1 : 0), "R8 transfer strobe count", n_xfer, kind == 1 ? 1 : 0);
    chk(n_halt == ((kind == 1 && !halted) ? 1 : 0), "R8 halt request count", n_halt,
        (kind == 1 && !halted) ? 1 : 0);
    chk(n_mreq == (kind == 2 ? 1 : 0), "R4 memory request count", n_mreq, kind == 2 ? 1 : 0);
    chk((n_rdy > 0) == has_rdy(kind), "R4 ready by kind", n_rdy > 0, has_rdy(kind));
    chk(n_capbad == 0, "R11 captured direction and byte enable", n_capbad, 0);
  endtask

  initial begin
    #(20ns * 150000);
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    chk(!bus_en_o && drv_en_o && !rdy_o && !mem_req_o && !xfer_o && !halt_req_o,
        "R1 reset state", bus_en_o, 0);
    #1; rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_en_o && drv_en_o && !rdy_o && !mem_req_o && !xfer_o && !halt_req_o,
        "R1 after reset", drv_en_o, 1);
    // directed: each kind at both depths
    for (int k = 0; k < 4; k++) begin
      run_txn(k, 1'b0, 1'b0, 3, 6, 1'b0);
      run_txn(k, 1'b1, 1'b1, 7, 8, 1'b0);
    end
    run_txn(1, 1'b0, 1'b1, 2, 6, 1'b0);
    // R12: release and memory done together
    run_txn(2, 1'b0, 1'b0, 2, 2, 1'b1);
    run_txn(2, 1'b1, 1'b0, 4, 2, 1'b1);
    // random mix
    for (int t = 0; t < 50; t++) begin
      int k;
      k = int'($urandom_range(3, 0));
      run_txn(k, 1'($urandom), 1'($urandom), int'($urandom_range(12, 0)),
              int'($urandom_range(10, 6)), (k == 2) && ($urandom_range(3, 0) == 0));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule